// File: doc/BRIEF.md
# Hardware-Triggered DMA Start Controller

This block sits between a set of peripherals and a DMA transfer engine and decides which peripheral request lines are allowed to start a transfer. Each channel carries three bits of state: an enable written by software, a suppression mask that hardware raises and software lowers, and a completion flag that hardware raises when a transfer it started finishes normally and software acknowledges. A request is pending only when its line is high, its channel is enabled and its mask is low. The lowest-numbered pending channel is offered to the engine and held until the engine acknowledges the start.

The transfer engine reports events back through strobes carrying a channel index: an error, a descriptor close (with a flag asking for the mask to be raised), and a normal end (with a flag asking for an interrupt). A standby strobe raises every mask at once. For each channel, the enable bit also chooses what reaches the interrupt controller: the peripheral's own interrupt when the channel is disabled, the completion flag when it is enabled.

Software reaches the state through a flat register port with single-cycle writes and a combinational read path. Channel n always sits at data bit n.

Top module: `dreq_ctl`

## Requirements
- R1: Address 0 holds the enable bits, read and written by software at bits [NCH-1:0]; write data above bit NCH-1 is dropped, and hardware events never change the enable bits.
- R2: A request line whose channel enable is 0 never causes a start offer.
- R3: Interrupt output bit n equals the peripheral interrupt n while enable n is 0, and equals completion flag n while enable n is 1.
- R4: Address 1 reads the mask bits and ignores writes; an error strobe for channel n sets mask n on the next clock edge, after which requests on channel n are not offered.
- R5: A standby strobe sets every channel's mask bit on the same clock edge.
- R6: A descriptor-close strobe for channel n sets mask n when its mask-on-close flag is 1 and leaves the mask unchanged when that flag is 0.
- R7: Writing data with bit n set to address 2 clears mask n; a request held on channel n is then offered on the following edge.
- R8: Address 3 reads the completion flags and ignores writes; a normal-end strobe for channel n sets flag n only when its interrupt flag is 1.
- R9: Writing data with bit n set to address 4 clears completion flag n.
- R10: The lowest-numbered pending channel is offered one edge after it becomes pending; while the offer is unacknowledged, the offered channel stays fixed even if a lower channel becomes pending, and an acknowledge drops the offer on the next edge.
- R11: When a hardware set and a software clear reach the same mask or flag bit on the same edge, the bit ends up set.
- R12: Reset clears all enable, mask and flag bits and removes any offer; unused addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data, combinational |
| dreq | input | NCH | Peripheral request lines |
| pirq | input | NCH | Peripheral interrupt lines |
| err_vld | input | 1 | Transfer error strobe |
| err_ch | input | CW | Channel of the error |
| standby | input | 1 | Standby command strobe |
| close_vld | input | 1 | Descriptor-close strobe |
| close_ch | input | CW | Channel of the close |
| close_mset | input | 1 | Mask-on-close flag of the closed descriptor |
| done_vld | input | 1 | Normal transfer end strobe |
| done_ch | input | CW | Channel of the transfer end |
| done_ie | input | 1 | Interrupt flag of the finishing descriptor |
| start_req | output | 1 | Start offer to the engine |
| start_ch | output | CW | Offered channel |
| start_ack | input | 1 | Engine accepts the offer |
| irq | output | NCH | Interrupt lines toward the interrupt controller |

## Verification
The bench builds the block with five channels and an eight-bit data path. Five channels give a channel index of three bits, so indices 5 to 7 exist on the strobes but name no channel, and the top three data bits of every write fall outside the channel range, which brings the dropping of those bits and the zero read-back into reach. Five is also not a power of two, which exercises the priority chain and the standby set across a channel count that does not fill its index.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_ENABLE = 3'd0,
      RA_MASK   = 3'd1,
      RA_MCLR   = 3'd2,
      RA_FLAG   = 3'd3,
      RA_FCLR   = 3'd4
   } reg_addr_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dreq_regs.sv
module dreq_regs
   import dreq_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned DW  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   input  logic [NCH-1:0]    mask,
   input  logic [NCH-1:0]    flag,
   output logic [NCH-1:0]    en,
   output logic [NCH-1:0]    mclr,
   output logic [NCH-1:0]    fclr,
   output logic [DW-1:0]     rd_data
);
   logic [NCH-1:0] wr_chan;

   assign wr_chan = wr_data[NCH-1:0];

   generate
      if (NCH < DW) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^wr_data[DW-1:NCH];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= '0;
      end else if (wr_en && (wr_addr == RA_ENABLE)) begin
         en <= wr_chan;
      end
   end

   assign mclr = (wr_en && (wr_addr == RA_MCLR)) ? wr_chan : '0;
   assign fclr = (wr_en && (wr_addr == RA_FCLR)) ? wr_chan : '0;

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         RA_ENABLE: rd_data[NCH-1:0] = en;
         RA_MASK:   rd_data[NCH-1:0] = mask;
         RA_FLAG:   rd_data[NCH-1:0] = flag;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/dreq_chan.sv
module dreq_chan #(
   parameter int unsigned CW  = 3,
   parameter int unsigned IDX = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          err_vld,
   input  logic [CW-1:0] err_ch,
   input  logic          standby,
   input  logic          close_vld,
   input  logic [CW-1:0] close_ch,
   input  logic          close_mset,
   input  logic          done_vld,
   input  logic [CW-1:0] done_ch,
   input  logic          done_ie,
   input  logic          mclr,
   input  logic          fclr,
   output logic          mask,
   output logic          flag
);
   localparam logic [CW-1:0] ME = CW'(IDX);

   logic mask_set;
   logic flag_set;

   assign mask_set = standby
                   | (err_vld && (err_ch == ME))
                   | (close_vld && close_mset && (close_ch == ME));
   assign flag_set = done_vld && done_ie && (done_ch == ME);

   // hardware set takes precedence over a software clear (R11)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (mask_set)  mask <= 1'b1;
         else if (mclr) mask <= 1'b0;
         if (flag_set)  flag <= 1'b1;
         else if (fclr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/dreq_arb.sv
module dreq_arb #(
   parameter int unsigned NCH = 8,
   parameter int unsigned CW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] pend,
   input  logic           start_ack,
   output logic           start_req,
   output logic [CW-1:0]  start_ch
);
   logic          any_pend;
   logic [CW-1:0] pick;

   assign any_pend = |pend;

   always_comb begin
      pick = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pend[i]) pick = CW'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_req <= 1'b0;
         start_ch  <= '0;
      end else if (start_req) begin
         if (start_ack) start_req <= 1'b0;
      end else if (any_pend) begin
         start_req <= 1'b1;
         start_ch  <= pick;
      end
   end
endmodule

// File: rtl/dreq_ctl.sv
module dreq_ctl
   import dreq_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned DW  = 32,
   parameter int unsigned CW  = idx_width(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic [NCH-1:0]    dreq,
   input  logic [NCH-1:0]    pirq,
   input  logic              err_vld,
   input  logic [CW-1:0]     err_ch,
   input  logic              standby,
   input  logic              close_vld,
   input  logic [CW-1:0]     close_ch,
   input  logic              close_mset,
   input  logic              done_vld,
   input  logic [CW-1:0]     done_ch,
   input  logic              done_ie,
   output logic              start_req,
   output logic [CW-1:0]     start_ch,
   input  logic              start_ack,
   output logic [NCH-1:0]    irq
);
   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $error("dreq_ctl: NCH must lie in 1..DW");
      end
      if (CW < idx_width(NCH)) begin : g_bad_cw
         $error("dreq_ctl: CW too narrow for NCH");
      end
   endgenerate

   logic [NCH-1:0] en;
   logic [NCH-1:0] mask;
   logic [NCH-1:0] flag;
   logic [NCH-1:0] mclr;
   logic [NCH-1:0] fclr;
   logic [NCH-1:0] pend;

   dreq_regs #(.NCH(NCH), .DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .mask    (mask),
      .flag    (flag),
      .en      (en),
      .mclr    (mclr),
      .fclr    (fclr),
      .rd_data (rd_data)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         dreq_chan #(.CW(CW), .IDX(c)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .err_vld    (err_vld),
            .err_ch     (err_ch),
            .standby    (standby),
            .close_vld  (close_vld),
            .close_ch   (close_ch),
            .close_mset (close_mset),
            .done_vld   (done_vld),
            .done_ch    (done_ch),
            .done_ie    (done_ie),
            .mclr       (mclr[c]),
            .fclr       (fclr[c]),
            .mask       (mask[c]),
            .flag       (flag[c])
         );
         assign pend[c] = dreq[c] & en[c] & ~mask[c];
         assign irq[c]  = en[c] ? flag[c] : pirq[c];
      end
   endgenerate

   dreq_arb #(.NCH(NCH), .CW(CW)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (pend),
      .start_ack (start_ack),
      .start_req (start_req),
      .start_ch  (start_ch)
   );
endmodule

// File: rtl/dreq_chk.sv
module dreq_chk
   import dreq_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned CW  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] wr_addr,
   input logic              err_vld,
   input logic [CW-1:0]     err_ch,
   input logic              standby,
   input logic              done_vld,
   input logic [CW-1:0]     done_ch,
   input logic              done_ie,
   input logic [NCH-1:0]    dreq,
   input logic              start_req,
   input logic [CW-1:0]     start_ch,
   input logic              start_ack,
   input logic [NCH-1:0]    en,
   input logic [NCH-1:0]    mask,
   input logic [NCH-1:0]    flag
);
   assert_en_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_addr == RA_ENABLE)) |=> $stable(en));

   assert_offer_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_req) |-> (((NCH'(1) << start_ch) & $past(dreq & en & ~mask)) != '0));

   // R11: set wins even against a same-cycle clear
   assert_err_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && (32'(err_ch) < NCH)) |=> mask[$past(err_ch)]);

   assert_standby_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (&mask));

   // R11: set wins even against a same-cycle clear
   assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && done_ie && (32'(done_ch) < NCH)) |=> flag[$past(done_ch)]);

   assert_offer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !start_ack) |=> (start_req && $stable(start_ch)));

   assert_offer_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && start_ack) |=> !start_req);
endmodule

bind dreq_ctl dreq_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .err_vld   (err_vld),
   .err_ch    (err_ch),
   .standby   (standby),
   .done_vld  (done_vld),
   .done_ch   (done_ch),
   .done_ie   (done_ie),
   .dreq      (dreq),
   .start_req (start_req),
   .start_ch  (start_ch),
   .start_ack (start_ack),
   .en        (en),
   .mask      (mask),
   .flag      (flag)
);

// File: tb/sim_dreq_ctl.sv
`timescale 1ns/1ps
module sim_dreq_ctl;
   localparam int NCH = 5;
   localparam int DW  = 8;
   localparam int CW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [NCH-1:0] dreq = '0;
   logic [NCH-1:0] pirq = '0;
   logic          err_vld = 1'b0;
   logic [CW-1:0] err_ch = '0;
   logic          standby = 1'b0;
   logic          close_vld = 1'b0;
   logic [CW-1:0] close_ch = '0;
   logic          close_mset = 1'b0;
   logic          done_vld = 1'b0;
   logic [CW-1:0] done_ch = '0;
   logic          done_ie = 1'b0;
   logic          start_req;
   logic [CW-1:0] start_ch;
   logic          start_ack = 1'b0;
   logic [NCH-1:0] irq;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   dreq_ctl #(.NCH(NCH), .DW(DW), .CW(CW)) u0 (.*);

   // op(1) addr(3) data(8) expect(8): op 0 = write, 1 = read and compare
   localparam logic [19:0] VEC [12] = '{
      {1'b0, 3'd0, 8'h1F, 8'h00},
      {1'b1, 3'd0, 8'h00, 8'h1F},
      {1'b0, 3'd0, 8'hFF, 8'h00},
      {1'b1, 3'd0, 8'h00, 8'h1F},
      {1'b0, 3'd1, 8'h1F, 8'h00},
      {1'b1, 3'd1, 8'h00, 8'h00},
      {1'b0, 3'd3, 8'h1F, 8'h00},
      {1'b1, 3'd3, 8'h00, 8'h00},
      {1'b0, 3'd0, 8'h05, 8'h00},
      {1'b1, 3'd0, 8'h00, 8'h05},
      {1'b1, 3'd7, 8'h00, 8'h00},
      {1'b1, 3'd5, 8'h00, 8'h00}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input int act, input int exp, input string tag);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1;
      wr_addr = 3'(a);
      wr_data = DW'(d);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      rd_addr = 3'(a);
      #1;
      chk(int'(rd_data), exp, tag);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      pirq = 5'h0A;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      // R12 reset state
      rd_chk(0, 0, "R12 enable after reset");
      rd_chk(1, 0, "R12 mask after reset");
      rd_chk(3, 0, "R12 flag after reset");
      chk(int'(start_req), 0, "R12 no offer after reset");
      chk(int'(irq), 'h0A, "R3 passthrough when disabled");

      // table of register vectors: R1 R4 R8 R12
      for (int i = 0; i < 12; i++) begin
         if (VEC[i][19] == 1'b0) begin
            wr(int'(VEC[i][18:16]), int'(VEC[i][15:8]));
         end else begin
            case (VEC[i][18:16])
               3'd0:    rd_chk(int'(VEC[i][18:16]), int'(VEC[i][7:0]), "R1 enable readback");
               3'd1:    rd_chk(int'(VEC[i][18:16]), int'(VEC[i][7:0]), "R4 mask ignores write");
               3'd3:    rd_chk(int'(VEC[i][18:16]), int'(VEC[i][7:0]), "R8 flag ignores write");
               default: rd_chk(int'(VEC[i][18:16]), int'(VEC[i][7:0]), "R12 unused address");
            endcase
         end
      end

      // R2: disabled requests never offered
      wr(0, 0);
      dreq = 5'h1F;
      tick(); tick(); tick();
      chk(int'(start_req), 0, "R2 disabled requests");
      dreq = '0;
      tick();

      // R3 / R8 / R9
      wr(0, 'h05);
      pirq = 5'h1F;
      #1;
      chk(int'(irq), 'h1A, "R3 selection no flags");
      done_vld = 1'b1; done_ch = 3'd2; done_ie = 1'b1;
      tick();
      done_ch = 3'd0; done_ie = 1'b0;
      tick();
      done_ch = 3'd4; done_ie = 1'b1;
      tick();
      done_vld = 1'b0; done_ie = 1'b0;
      rd_chk(3, 'h14, "R8 flag set only with interrupt flag");
      chk(int'(irq), 'h1E, "R3 enabled channel shows flag");
      pirq = '0;
      #1;
      chk(int'(irq), 'h04, "R3 selection pirq low");
      wr(4, 'h04);
      rd_chk(3, 'h10, "R9 flag clear bit2");
      wr(4, 'h10);
      rd_chk(3, 'h00, "R9 flag clear bit4");

      // R10 priority and hold
      wr(0, 'h1F);
      rd_chk(0, 'h1F, "R1 enable not changed by events");
      dreq = 5'h16;
      tick();
      chk(int'(start_req), 1, "R10 offer raised");
      chk(int'(start_ch), 1, "R10 lowest pending");
      dreq = 5'h17;
      tick(); tick();
      chk(int'(start_ch), 1, "R10 offer held");
      start_ack = 1'b1;
      tick();
      start_ack = 1'b0;
      chk(int'(start_req), 0, "R10 offer dropped on ack");
      tick();
      chk(int'(start_req), 1, "R10 re-offer");
      chk(int'(start_ch), 0, "R10 new lowest channel");
      dreq = '0;
      start_ack = 1'b1;
      tick();
      start_ack = 1'b0;
      tick();

      // R4 error mask, R7 clear
      err_vld = 1'b1; err_ch = 3'd1;
      tick();
      err_vld = 1'b0;
      rd_chk(1, 'h02, "R4 error sets mask");
      wr(1, 'h00);
      rd_chk(1, 'h02, "R4 mask write ignored");
      dreq = 5'h02;
      tick(); tick(); tick();
      chk(int'(start_req), 0, "R4 masked request suppressed");
      wr(2, 'h02);
      rd_chk(1, 'h00, "R7 mask cleared");
      tick();
      chk(int'(start_req), 1, "R7 request recognised after clear");
      chk(int'(start_ch), 1, "R7 offered channel");
      dreq = '0;
      start_ack = 1'b1;
      tick();
      start_ack = 1'b0;

      // R6 close
      close_vld = 1'b1; close_ch = 3'd3; close_mset = 1'b0;
      tick();
      rd_chk(1, 'h00, "R6 close without mask flag");
      close_mset = 1'b1;
      tick();
      close_vld = 1'b0; close_mset = 1'b0;
      rd_chk(1, 'h08, "R6 close with mask flag");

      // R5 standby
      standby = 1'b1;
      tick();
      standby = 1'b0;
      rd_chk(1, 'h1F, "R5 standby masks all");
      wr(2, 'hFF);
      rd_chk(1, 'h00, "R7 clear all masks");

      // R11 set beats clear
      err_vld = 1'b1; err_ch = 3'd2;
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h04;
      tick();
      err_vld = 1'b0; wr_en = 1'b0;
      rd_chk(1, 'h04, "R11 mask set wins");
      done_vld = 1'b1; done_ch = 3'd0; done_ie = 1'b1;
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
      tick();
      done_vld = 1'b0; done_ie = 1'b0; wr_en = 1'b0;
      rd_chk(3, 'h01, "R11 flag set wins");

      // R12 reset mid-run
      rst_n = 1'b0;
      #1;
      rd_chk(0, 0, "R12 enable cleared");
      rd_chk(1, 0, "R12 mask cleared");
      rd_chk(3, 0, "R12 flag cleared");
      tick();
      rst_n = 1'b1;
      tick();
      summary();
   end
endmodule